// File: doc/BRIEF.md
# Dual Parallel Port Register Block

This block gives a processor two 8-bit parallel ports, named A and B, through sixteen byte-wide register slots on a small synchronous bus. Each port holds an output byte and a direction byte. A pin whose direction bit is 1 is driven with its output bit. A pin whose direction bit is 0 is released. The pad ring receives the output byte and an output-enable vector for each port, and builds the tri-state buffers from them.

The block also keeps a stored peripheral-control byte and a small interrupt unit. Seven interrupt sources raise flag bits with one-cycle set pulses. Software clears flags by writing ones to the flag register. It sets or clears enable bits through a write protocol that uses bit 7 as the mode. The interrupt output is high while any flag is set together with its enable bit.

The bus carries register accesses and not a data stream, so it has no valid/ready handshake. A write completes on the rising clock edge where `bus_wr` is high. Read data follows the address combinationally while `bus_rd` is high and is zero otherwise. The bus never stalls.

Top module: `pio_ctrl`

## Requirements
- R1: After reset, both output bytes read 0xFF, both direction bytes read 0x00, the control, flag and enable bytes are 0x00, and `irq` is low.
- R2: The four port bytes sit at fixed offsets: 0x0 is port B output, 0x1 is port A output, 0x2 is port B direction and 0x3 is port A direction. Each reads back the last value written to it.
- R3: A write to offset 0xF loads port A's output byte exactly as a write to 0x1 does. A read of 0xF returns 0x00.
- R4: `pa_out`/`pb_out` equal the port's output byte, and `pa_oe`/`pb_oe` equal the port's direction byte (1 = driven, 0 = released).
- R5: Offset 0xC holds a control byte that is only stored and read back.
- R6: A write to the flag register at 0xD clears each flag in bits 6:0 whose written bit is 1. Written zeros, and written bit 7, change nothing.
- R7: A write to the enable register at 0xE with bit 7 = 1 sets each enable bit in 6:0 written as 1. With bit 7 = 0 it clears each enable bit in 6:0 written as 1. Other enable bits keep their values.
- R8: Reading offset 0xE returns the enable bits in 6:0 with bit 7 always 1.
- R9: Reading offset 0xD returns the flags in 6:0. Bit 7 reads 1 exactly when some bit is set in both flags and enables, and `irq` follows the same condition.
- R10: A high bit of `irq_set` sets the matching flag on that clock edge. If a flag-clear write hits the same bit in the same cycle, the flag still ends up set.
- R11: Offsets 0x4 to 0xB read as 0x00, and writes to them change no register.
- R12: While `bus_rd` is low, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_rd | input | 1 | Read strobe, enables read data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_set | input | 7 | One-cycle set pulses from interrupt sources |
| irq | output | 1 | Active-high interrupt request |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 8 | Port A per-pin output enables |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 8 | Port B per-pin output enables |

## Verification
The checker checks several things on every cycle. Read data is zero whenever no read is under way, and unmapped offsets read zero. Bit 7 of an enable read is always 1, and the summary bit of a flag read always matches `irq`. After a write, the new values show at the port pins. Set pulses always land, and a clear write or a clear-mode enable write always removes the bits it names. Some behaviours need the bench's scenarios and its reference model. These are the reset contents, the set-versus-clear collision, writes to unmapped offsets leaving every register unchanged, and the combined result of long random mixes of writes and pulses.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 8;
  localparam int IRQ_W     = DATA_W - 1;
  localparam int NUM_PORTS = 2;
  // port index 0 is port B, index 1 is port A (follows offset order)
  localparam int IDX_B = 0;
  localparam int IDX_A = 1;

  localparam logic [ADDR_W-1:0] OFS_B_DATA = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_A_DATA = 4'h1;
  localparam logic [ADDR_W-1:0] OFS_B_DIR  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_A_DIR  = 4'h3;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'hC;
  localparam logic [ADDR_W-1:0] OFS_FLAG   = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_ENAB   = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_A_ALT  = 4'hF;

  localparam logic [DATA_W-1:0] DATA_RST = '1;
  localparam logic [DATA_W-1:0] DIR_RST  = '0;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    logic [NUM_PORTS-1:0] data_we;
    logic [NUM_PORTS-1:0] dir_we;
    logic                 ctrl_we;
    logic                 flag_we;
    logic                 enab_we;
  } wr_sel_t;
endpackage

// File: rtl/pio_port_reg.sv
module pio_port_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] DATA_INIT = '1,
  parameter logic [W-1:0] DIR_INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] data_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_INIT;
      dir_q  <= DIR_INIT;
    end else begin
      if (data_we) data_q <= wdata;
      if (dir_we)  dir_q  <= wdata;
    end
  end

  // pads: driven where direction bit is 1, released where it is 0
  assign pin_out = data_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flag_we,
  input  logic         enab_we,
  input  logic [N:0]   wdata,
  input  logic [N-1:0] set_pulse,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] enab_q,
  output logic         pending
);
  logic [N-1:0] flag_d;
  logic [N-1:0] enab_d;
  logic         set_mode;

  assign set_mode = wdata[N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      // a source pulse overrides a same-cycle clear
      if (set_pulse[i])
        flag_d[i] = 1'b1;
      else if (flag_we && wdata[i])
        flag_d[i] = 1'b0;
      else
        flag_d[i] = flag_q[i];

      if (enab_we && wdata[i])
        enab_d[i] = set_mode;
      else
        enab_d[i] = enab_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      enab_q <= '0;
    end else begin
      flag_q <= flag_d;
      enab_q <= enab_d;
    end
  end

  assign pending = |(flag_q & enab_q);
endmodule

// File: rtl/pio_bus_dec.sv
module pio_bus_dec
  import pio_pkg::*;
(
  input  logic [ADDR_W-1:0]                 addr,
  input  logic                              wr,
  input  logic                              rd,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  port_data,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  port_dir,
  input  logic [DATA_W-1:0]                 ctrl,
  input  logic [IRQ_W-1:0]                  flags,
  input  logic [IRQ_W-1:0]                  enables,
  input  logic                              pending,
  output wr_sel_t                           sel,
  output logic [DATA_W-1:0]                 rdata
);
  always_comb begin
    sel = '0;
    if (wr) begin
      unique case (addr)
        OFS_B_DATA: sel.data_we[IDX_B] = 1'b1;
        OFS_A_DATA,
        OFS_A_ALT:  sel.data_we[IDX_A] = 1'b1;
        OFS_B_DIR:  sel.dir_we[IDX_B]  = 1'b1;
        OFS_A_DIR:  sel.dir_we[IDX_A]  = 1'b1;
        OFS_CTRL:   sel.ctrl_we        = 1'b1;
        OFS_FLAG:   sel.flag_we        = 1'b1;
        OFS_ENAB:   sel.enab_we        = 1'b1;
        default:    sel                = '0;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        OFS_B_DATA: rdata = port_data[IDX_B];
        OFS_A_DATA: rdata = port_data[IDX_A];
        OFS_B_DIR:  rdata = port_dir[IDX_B];
        OFS_A_DIR:  rdata = port_dir[IDX_A];
        OFS_CTRL:   rdata = ctrl;
        OFS_FLAG:   rdata = {pending, flags};
        OFS_ENAB:   rdata = {1'b1, enables};
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [IRQ_W-1:0]      irq_set,
  output logic                  irq,
  output logic [DATA_W-1:0]     pa_out,
  output logic [DATA_W-1:0]     pa_oe,
  output logic [DATA_W-1:0]     pb_out,
  output logic [DATA_W-1:0]     pb_oe
);
  wr_sel_t                          sel;
  logic [NUM_PORTS-1:0][DATA_W-1:0] port_data;
  logic [NUM_PORTS-1:0][DATA_W-1:0] port_dir;
  logic [NUM_PORTS-1:0][DATA_W-1:0] port_pin;
  logic [NUM_PORTS-1:0][DATA_W-1:0] port_oe;
  logic [DATA_W-1:0]                ctrl_q;
  logic [IRQ_W-1:0]                 flag_q;
  logic [IRQ_W-1:0]                 en_q;
  logic                             pending;

  pio_bus_dec u_dec (
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .port_data (port_data),
    .port_dir  (port_dir),
    .ctrl      (ctrl_q),
    .flags     (flag_q),
    .enables   (en_q),
    .pending   (pending),
    .sel       (sel),
    .rdata     (bus_rdata)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    pio_port_reg #(
      .W         (DATA_W),
      .DATA_INIT (DATA_RST),
      .DIR_INIT  (DIR_RST)
    ) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_we (sel.data_we[p]),
      .dir_we  (sel.dir_we[p]),
      .wdata   (bus_wdata),
      .data_q  (port_data[p]),
      .dir_q   (port_dir[p]),
      .pin_out (port_pin[p]),
      .pin_oe  (port_oe[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctrl_q <= '0;
    else if (sel.ctrl_we) ctrl_q <= bus_wdata;
  end

  pio_irq_ctrl #(.N(IRQ_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_we   (sel.flag_we),
    .enab_we   (sel.enab_we),
    .wdata     (bus_wdata),
    .set_pulse (irq_set),
    .flag_q    (flag_q),
    .enab_q    (en_q),
    .pending   (pending)
  );

  assign irq    = pending;
  assign pa_out = port_pin[IDX_A];
  assign pa_oe  = port_oe[IDX_A];
  assign pb_out = port_pin[IDX_B];
  assign pb_oe  = port_oe[IDX_B];
endmodule

// File: rtl/pio_ctrl_checker.sv
module pio_ctrl_checker
  import pio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [IRQ_W-1:0]  irq_set,
  input logic              irq,
  input logic [DATA_W-1:0] pa_out,
  input logic [DATA_W-1:0] pa_oe,
  input logic [DATA_W-1:0] pb_out,
  input logic [DATA_W-1:0] pb_oe,
  input logic [IRQ_W-1:0]  flag_q,
  input logic [IRQ_W-1:0]  en_q
);
  assert_port_a_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFS_A_DATA |=> pa_out == $past(bus_wdata));

  assert_alt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFS_A_ALT |=> pa_out == $past(bus_wdata));

  assert_dir_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFS_B_DIR |=> pb_oe == $past(bus_wdata));

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFS_FLAG && irq_set == '0
    |=> (flag_q & $past(bus_wdata[IRQ_W-1:0])) == '0);

  assert_enab_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == OFS_ENAB && !bus_wdata[IRQ_W]
    |=> (en_q & $past(bus_wdata[IRQ_W-1:0])) == '0);

  assert_enab_top_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == OFS_ENAB |-> bus_rdata[DATA_W-1]);

  assert_summary_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == OFS_FLAG |-> bus_rdata[DATA_W-1] == irq);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set != '0 |=> (flag_q & $past(irq_set)) == $past(irq_set));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr > OFS_A_DIR && bus_addr < OFS_CTRL |-> bus_rdata == '0);

  assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
endmodule

bind pio_ctrl pio_ctrl_checker u_pio_ctrl_checker (.*);

// File: tb/pio_ctrl_bench.sv
module pio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] irq_set = '0;
  logic       irq;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;

  int n_chk = 0;
  int n_fail = 0;

  // reference model, index 0 = port B, 1 = port A
  logic [7:0] m_data [2];
  logic [7:0] m_dir  [2];
  logic [7:0] m_ctrl;
  logic [6:0] m_flag;
  logic [6:0] m_en;

  always #4 clk = ~clk;

  pio_ctrl u_pio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_set(irq_set), .irq(irq), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_out(pb_out), .pb_oe(pb_oe)
  );

  function automatic logic m_pend();
    return |(m_flag & m_en);
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return m_data[0];
      4'h1: return m_data[1];
      4'h2: return m_dir[0];
      4'h3: return m_dir[1];
      4'hC: return m_ctrl;
      4'hD: return {m_pend(), m_flag};
      4'hE: return {1'b1, m_en};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      4'h0, 4'h1, 4'h2, 4'h3: return "R2";
      4'hC: return "R5";
      4'hD: return "R9";
      4'hE: return "R8";
      4'hF: return "R3";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    m_data[0] = 8'hFF; m_data[1] = 8'hFF;
    m_dir[0] = 8'h00;  m_dir[1] = 8'h00;
    m_ctrl = 8'h00; m_flag = '0; m_en = '0;
  endtask

  task automatic model_apply(input logic w, input logic [3:0] a,
                             input logic [7:0] d, input logic [6:0] s);
    if (w) begin
      case (a)
        4'h0: m_data[0] = d;
        4'h1, 4'hF: m_data[1] = d;
        4'h2: m_dir[0] = d;
        4'h3: m_dir[1] = d;
        4'hC: m_ctrl = d;
        4'hD: m_flag = m_flag & ~d[6:0];
        4'hE: m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
        default: ;
      endcase
    end
    m_flag = m_flag | s;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic bus_cycle(input logic w, input logic [3:0] a,
                           input logic [7:0] d, input logic [6:0] s);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; irq_set = s;
    @(negedge clk);
    bus_wr = 1'b0; irq_set = '0;
    model_apply(w, a, d, s);
  endtask

  task automatic read_check(input logic [3:0] a, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    check(tag == "" ? req_of(a) : tag, bus_rdata, exp_read(a));
    #1;
    bus_rd = 1'b0;
  endtask

  task automatic scan(input string tag);
    for (int a = 0; a < 16; a++) read_check(4'(a), tag);
    check(tag == "" ? "R4" : tag, pa_out, m_data[1]);
    check(tag == "" ? "R4" : tag, pa_oe,  m_dir[1]);
    check(tag == "" ? "R4" : tag, pb_out, m_data[0]);
    check(tag == "" ? "R4" : tag, pb_oe,  m_dir[0]);
    check(tag == "" ? "R9" : tag, {7'd0, irq}, {7'd0, m_pend()});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd1729);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    scan("R1");

    // R12: no read strobe gives zero data
    @(negedge clk); bus_addr = 4'h1; bus_rd = 1'b0; #1;
    check("R12", bus_rdata, 8'h00);

    // R2 / R4 directed
    bus_cycle(1'b1, 4'h0, 8'h5A, '0);
    bus_cycle(1'b1, 4'h2, 8'hC3, '0);
    check("R4", pb_out, 8'h5A);
    check("R4", pb_oe, 8'hC3);

    // R3: alternate write path
    bus_cycle(1'b1, 4'hF, 8'h96, '0);
    read_check(4'h1, "R3");
    read_check(4'hF, "R3");
    check("R3", pa_out, 8'h96);

    // R5
    bus_cycle(1'b1, 4'hC, 8'hA7, '0);
    read_check(4'hC, "R5");

    // R7 set then clear mode, R8
    bus_cycle(1'b1, 4'hE, 8'hFF, '0);
    read_check(4'hE, "R7");
    bus_cycle(1'b1, 4'hE, 8'h05, '0);
    read_check(4'hE, "R7");
    check("R8", exp_read(4'hE), 8'hFA);

    // R10 pulses, R9 pending
    bus_cycle(1'b0, 4'h0, 8'h00, 7'h41);
    read_check(4'hD, "R10");
    check("R9", {7'd0, irq}, 8'h01);

    // R6: clear one flag, written zeros untouched
    bus_cycle(1'b1, 4'hD, 8'h80 | 8'h40, '0);
    read_check(4'hD, "R6");
    check("R6", exp_read(4'hD), 8'h01);

    // R10: set and clear same bit same cycle
    bus_cycle(1'b1, 4'hD, 8'h7F, 7'h08);
    read_check(4'hD, "R10");
    check("R10", exp_read(4'hD), 8'h88);

    // R9: masked flag gives no interrupt
    bus_cycle(1'b1, 4'hE, 8'h08, '0);
    read_check(4'hD, "R9");
    check("R9", {7'd0, irq}, 8'h00);

    // R11: unmapped writes change nothing
    for (int a = 4; a < 12; a++) bus_cycle(1'b1, 4'(a), 8'h3C, '0);
    scan("R11");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [3:0] a;
      logic [7:0] d;
      logic [6:0] s;
      a = 4'($urandom % 16);
      d = 8'($urandom);
      s = ($urandom % 4 == 0) ? 7'($urandom) : 7'd0;
      bus_cycle(($urandom % 8) != 0, a, d, s);
      if (it % 4 == 3) scan("");
    end
    scan("");

    // reset mid-run returns to R1 state
    @(negedge clk); rst_n = 1'b0;
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    scan("R1");

    finish_run();
  end
endmodule